// File: doc/BRIEF.md
# Host Memory Window Slave

This block sits on the device side of a host I/O port. It exposes a private word-organised RAM to the host through eight consecutive byte registers. The host first loads a two-byte pointer. The low byte of that pointer also carries an access-type code. The host then moves data through four data byte registers, which map onto the four byte lanes of the 32-bit word the pointer selects. Two 8-bit mailbox registers give a simple message path in each direction. The host writes one of them, and the device writes the other through its own local port.

One access type makes streaming cheap: in 32-bit auto-increment mode, touching the highest data byte moves the pointer on to the next word. A host can therefore sweep a buffer with nothing but data-register cycles. Reads are combinational, so the byte is available in the same cycle as the read strobe.

Top module: `memwin_slave`

## Requirements
- R1: After reset, both mailbox registers, the word pointer and the access type are zero, so host reads at offsets 0, 1, 2 and 3 return 0x00.
- R2: A host write to offset 2 loads the access type from bits 1:0 and byte-address bits 7:2 from bits 7:2. A read of offset 2 returns the same packing: {address bits 7:2, type}.
- R3: A host write to offset 3 loads byte-address bits 14:8 from bits 6:0. Bit 7 is ignored, and a read of offset 3 always returns bit 7 as 0.
- R4: A host write to offset 4+n (n = 0..3) changes only byte lane n, which is bits 8n+7:8n, of the addressed word. The RAM holds 2^MEM_AW words and is indexed by the low MEM_AW bits of the word pointer.
- R5: A host read of offset 4+n returns lane n of the addressed word combinationally, in the cycle the read strobe is high.
- R6: With access type 3, any host read or write of offset 7 advances the word pointer by one after the access. The access itself uses the word selected before the advance.
- R7: With access types 0, 1 or 2, no data-register access changes the pointer.
- R8: With access type 3, an advance from word 0x1FFF (byte address 0x7FFC) wraps the pointer to zero.
- R9: A host write to offset 0 sets the host-to-device mailbox. A host write to offset 1 has no effect. A device-port write sets the device-to-host mailbox. Both mailboxes are readable by the host at offsets 0 and 1 and are driven on device outputs.
- R10: With access type 3, accesses to offsets 4, 5 and 6 leave the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 3 | Register offset within the window |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, combinational |
| dev_mbox_wr | input | 1 | Device write strobe for the device-to-host mailbox |
| dev_mbox_wdata | input | 8 | Device mailbox write data |
| dev_h2d | output | 8 | Current host-to-device mailbox value |
| dev_d2h | output | 8 | Current device-to-host mailbox value |

## Verification
A write to data byte 3 in auto-increment mode stores a lane and advances the pointer in the same cycle. The bench provokes this with streaming fills and random traffic. It judges the result by reading the lanes of both the old and the new word and by reading the pointer back through offsets 2 and 3. The wrap at the top of the space is also checked. A host write to mailbox 0 and a device mailbox write are also issued in the same cycle, and both registers must then hold their own values.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
  typedef enum logic [2:0] {
    OFF_H2D = 3'd0,
    OFF_D2H = 3'd1,
    OFF_ALO = 3'd2,
    OFF_AHI = 3'd3,
    OFF_D0  = 3'd4,
    OFF_D1  = 3'd5,
    OFF_D2  = 3'd6,
    OFF_D3  = 3'd7
  } win_off_e;

  typedef enum logic [1:0] {
    ACC_B8      = 2'd0,
    ACC_B16     = 2'd1,
    ACC_B32     = 2'd2,
    ACC_B32_INC = 2'd3
  } acc_e;

  localparam int LANES = 4;
endpackage

// File: rtl/memwin_addr_reg.sv
module memwin_addr_reg
  import memwin_pkg::*;
#(
  parameter int ADDR_W = 15,
  localparam int WA_W  = ADDR_W - 2,
  localparam int HI_W  = ADDR_W - 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we_lo,
  input  logic            we_hi,
  input  logic            data_acc,
  input  logic            top_lane_acc,
  input  logic [7:0]      lo_wdata,
  input  logic [HI_W-1:0] hi_wdata,
  output logic [WA_W-1:0] wa_q,
  output acc_e            type_q,
  output logic [7:0]      lo_rd,
  output logic [7:0]      hi_rd
);
  logic step;
  assign step = top_lane_acc && (type_q == ACC_B32_INC);

  always_ff @(posedge clk) begin
    if (rst) begin
      wa_q   <= '0;
      type_q <= ACC_B8;
    end else begin
      if (we_lo) begin
        type_q   <= acc_e'(lo_wdata[1:0]);
        wa_q[5:0] <= lo_wdata[7:2];
      end
      if (we_hi) wa_q[WA_W-1:6] <= hi_wdata;
      if (step)  wa_q <= wa_q + 1'b1;
    end
  end

  assign lo_rd = {wa_q[5:0], type_q};
  assign hi_rd = 8'(wa_q[WA_W-1:6]);

  // R6: an access to the top lane in auto-increment mode moves to the next word
  a_r6_step: assert property (@(posedge clk) disable iff (rst)
    (top_lane_acc && type_q == ACC_B32_INC && !we_lo && !we_hi)
      |=> (wa_q == WA_W'($past(wa_q) + 1'b1)));

  // R8: the pointer wraps from the last word to zero
  a_r8_wrap: assert property (@(posedge clk) disable iff (rst)
    (top_lane_acc && type_q == ACC_B32_INC && (&wa_q)) |=> (wa_q == '0));

  // R7: non-incrementing types keep the pointer across data accesses
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    (data_acc && type_q != ACC_B32_INC && !we_lo && !we_hi) |=> $stable(wa_q));

  // R10: lanes 0..2 never advance the pointer
  a_r10_low_lanes: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !top_lane_acc && !we_lo && !we_hi) |=> $stable(wa_q));
endmodule

// File: rtl/memwin_lane_ram.sv
module memwin_lane_ram #(
  parameter int MEM_AW = 10,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [MEM_AW-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

  // R4: a write lands in the addressed entry of this lane
  a_r4_lane_write: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(addr)] == $past(wdata)));
endmodule

// File: rtl/memwin_mbox.sv
module memwin_mbox (
  input  logic       clk,
  input  logic       rst,
  input  logic       host_we,
  input  logic [7:0] host_wdata,
  input  logic       dev_we,
  input  logic [7:0] dev_wdata,
  output logic [7:0] h2d_q,
  output logic [7:0] d2h_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      h2d_q <= '0;
      d2h_q <= '0;
    end else begin
      if (host_we) h2d_q <= host_wdata;
      if (dev_we)  d2h_q <= dev_wdata;
    end
  end

  // R9: each mailbox has exactly one writer
  a_r9_h2d_owner: assert property (@(posedge clk) disable iff (rst)
    !host_we |=> $stable(h2d_q));
  a_r9_d2h_owner: assert property (@(posedge clk) disable iff (rst)
    !dev_we |=> $stable(d2h_q));
endmodule

// File: rtl/memwin_slave.sv
module memwin_slave
  import memwin_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int MEM_AW = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] host_addr,
  input  logic       host_wr,
  input  logic       host_rd,
  input  logic [7:0] host_wdata,
  output logic [7:0] host_rdata,
  input  logic       dev_mbox_wr,
  input  logic [7:0] dev_mbox_wdata,
  output logic [7:0] dev_h2d,
  output logic [7:0] dev_d2h
);
  localparam int WA_W = ADDR_W - 2;
  localparam int HI_W = ADDR_W - 8;

  logic [WA_W-1:0] wa;
  acc_e            acc_type;
  logic [7:0]      alo_rd, ahi_rd;
  logic [7:0]      lane_rd [LANES];
  logic            any_acc, data_acc, top_acc;

  assign any_acc  = host_wr || host_rd;
  assign data_acc = any_acc && host_addr[2];
  assign top_acc  = any_acc && (host_addr == OFF_D3);

  memwin_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk          (clk),
    .rst          (rst),
    .we_lo        (host_wr && host_addr == OFF_ALO),
    .we_hi        (host_wr && host_addr == OFF_AHI),
    .data_acc     (data_acc),
    .top_lane_acc (top_acc),
    .lo_wdata     (host_wdata),
    .hi_wdata     (host_wdata[HI_W-1:0]),
    .wa_q         (wa),
    .type_q       (acc_type),
    .lo_rd        (alo_rd),
    .hi_rd        (ahi_rd)
  );

  for (genvar n = 0; n < LANES; n++) begin : g_lane
    localparam logic [2:0] LANE_OFF = 3'(4 + n);
    memwin_lane_ram #(.MEM_AW(MEM_AW)) u_ram (
      .clk   (clk),
      .rst   (rst),
      .we    (host_wr && host_addr == LANE_OFF),
      .addr  (wa[MEM_AW-1:0]),
      .wdata (host_wdata),
      .rdata (lane_rd[n])
    );
  end

  memwin_mbox u_mbox (
    .clk        (clk),
    .rst        (rst),
    .host_we    (host_wr && host_addr == OFF_H2D),
    .host_wdata (host_wdata),
    .dev_we     (dev_mbox_wr),
    .dev_wdata  (dev_mbox_wdata),
    .h2d_q      (dev_h2d),
    .d2h_q      (dev_d2h)
  );

  always_comb begin
    unique case (host_addr)
      OFF_H2D: host_rdata = dev_h2d;
      OFF_D2H: host_rdata = dev_d2h;
      OFF_ALO: host_rdata = alo_rd;
      OFF_AHI: host_rdata = ahi_rd;
      OFF_D0:  host_rdata = lane_rd[0];
      OFF_D1:  host_rdata = lane_rd[1];
      OFF_D2:  host_rdata = lane_rd[2];
      default: host_rdata = lane_rd[3];
    endcase
  end

  // R3: the unused top bit of the high pointer byte reads as zero
  a_r3_hi_bit7: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr == OFF_AHI) |-> !host_rdata[7]);

  // R1: the pointer and type are cleared by reset
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(rst) |-> (alo_rd == 8'h00 && ahi_rd == 8'h00));
endmodule

// File: tb/memwin_slave_tb.sv
module memwin_slave_tb;
  localparam int MEM_AW = 10;
  localparam int DEPTH  = 1 << MEM_AW;

  logic       clk = 0;
  logic       rst = 1;
  logic [2:0] host_addr = 0;
  logic       host_wr = 0, host_rd = 0;
  logic [7:0] host_wdata = 0;
  logic [7:0] host_rdata;
  logic       dev_mbox_wr = 0;
  logic [7:0] dev_mbox_wdata = 0;
  logic [7:0] dev_h2d, dev_d2h;

  always #2 clk = ~clk;

  memwin_slave #(.ADDR_W(15), .MEM_AW(MEM_AW)) u_dut (
    .clk, .rst, .host_addr, .host_wr, .host_rd, .host_wdata, .host_rdata,
    .dev_mbox_wr, .dev_mbox_wdata, .dev_h2d, .dev_d2h
  );

  int checks = 0, failures = 0;
  logic [31:0] m_mem [DEPTH];
  logic [12:0] m_wa = 0;
  logic [1:0]  m_ty = 0;
  logic [7:0]  m_h2d = 0, m_d2h = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] model_rd(int off);
    case (off)
      0: return m_h2d;
      1: return m_d2h;
      2: return {m_wa[5:0], m_ty};
      3: return {1'b0, m_wa[12:6]};
      default: return m_mem[m_wa[MEM_AW-1:0]][8*(off-4) +: 8];
    endcase
  endfunction

  function automatic void model_acc(bit wr, int off, logic [7:0] d);
    if (wr) begin
      case (off)
        0: m_h2d = d;
        2: begin m_ty = d[1:0]; m_wa[5:0] = d[7:2]; end
        3: m_wa[12:6] = d[6:0];
        4, 5, 6, 7: m_mem[m_wa[MEM_AW-1:0]][8*(off-4) +: 8] = d;
        default: ;
      endcase
    end
    if (off == 7 && m_ty == 2'd3) m_wa = m_wa + 1'b1;
  endfunction

  task automatic bus(bit wr, int off, logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    host_addr = 3'(off); host_wr = wr; host_rd = !wr; host_wdata = d;
    #1 r = host_rdata;
    @(posedge clk);
    #1 host_wr = 0; host_rd = 0;
  endtask

  task automatic hw(int off, logic [7:0] d);
    logic [7:0] r;
    bus(1, off, d, r);
    model_acc(1, off, d);
  endtask

  task automatic hr(int off, string tag, output logic [7:0] got);
    logic [7:0] e;
    e = model_rd(off);
    bus(0, off, 8'h00, got);
    chk(tag, got, e);
    model_acc(0, off, 8'h00);
  endtask

  task automatic dw(logic [7:0] d);
    @(negedge clk);
    dev_mbox_wr = 1; dev_mbox_wdata = d;
    @(posedge clk);
    #1 dev_mbox_wr = 0;
    m_d2h = d;
  endtask

  function automatic string tag_of(int off);
    case (off)
      0, 1: return "R9";
      2: return "R2";
      3: return "R3";
      default: return "R5";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] g;
    void'($urandom(32'h5eed_0042));
    repeat (3) @(posedge clk);
    #1 rst = 0;

    // R1: reset values
    for (int o = 0; o < 4; o++) begin
      hr(o, "R1", g);
      chk("R1", g, 8'h00);
    end

    // R6: fill all words by streaming in auto-increment mode
    hw(2, 8'h03); hw(3, 8'h00);
    for (int i = 0; i < DEPTH * 4; i++) hw(4 + (i % 4), 8'((i * 7 + 3) & 255));
    hr(2, "R6", g); chk("R6", g, 8'h03);
    hr(3, "R6", g); chk("R6", g, 8'h10);

    // R2 and R3: pointer packing and ignored bit 7
    hw(2, 8'hB7); hr(2, "R2", g); chk("R2", g, 8'hB7);
    hw(3, 8'hFF); hr(3, "R3", g); chk("R3", g, 8'h7F);

    // R4: a single lane write leaves the neighbours alone
    hw(2, 8'h40); hw(3, 8'h01);
    hw(5, 8'hC3);
    for (int o = 4; o < 8; o++) hr(o, "R4", g);
    hr(5, "R4", g); chk("R4", g, 8'hC3);

    // R7: type 2 accesses to the top lane keep the pointer
    hw(2, 8'h42); hw(7, 8'h11); hr(7, "R7", g);
    hr(2, "R7", g); chk("R7", g, 8'h42);
    hr(3, "R7", g); chk("R7", g, 8'h01);

    // R10: low lanes in auto-increment mode keep the pointer
    hw(2, 8'h43); hw(4, 8'h21); hr(5, "R10", g); hw(6, 8'h22);
    hr(2, "R10", g); chk("R10", g, 8'h43);

    // R6: top-lane write lands on the old word, then the pointer moves
    hw(7, 8'h9E);
    hr(2, "R6", g); chk("R6", g, 8'h47);
    hw(2, 8'h43);
    hr(7, "R6", g); chk("R6", g, 8'h9E);
    hr(2, "R6", g); chk("R6", g, 8'h47);

    // R8: wrap from the last word
    hw(2, 8'hFF); hw(3, 8'h7F);
    hw(7, 8'h5A);
    hr(2, "R8", g); chk("R8", g, 8'h03);
    hr(3, "R8", g); chk("R8", g, 8'h00);

    // R9: mailboxes, ignored host write to offset 1, same-cycle writes
    dw(8'h6C);
    hw(1, 8'hEE);
    hr(1, "R9", g); chk("R9", g, 8'h6C);
    @(negedge clk);
    host_addr = 3'd0; host_wr = 1; host_wdata = 8'hA5;
    dev_mbox_wr = 1; dev_mbox_wdata = 8'h3C;
    @(posedge clk);
    #1 host_wr = 0; dev_mbox_wr = 0;
    m_h2d = 8'hA5; m_d2h = 8'h3C;
    hr(0, "R9", g); chk("R9", g, 8'hA5);
    hr(1, "R9", g); chk("R9", g, 8'h3C);
    chk("R9", dev_h2d, 8'hA5);
    chk("R9", dev_d2h, 8'h3C);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int c, o;
      c = $urandom_range(0, 11);
      o = $urandom_range(4, 7);
      case (c)
        0, 1: hw(2, 8'($urandom));
        2: hw(3, 8'($urandom));
        3, 4, 5: hw(o, 8'($urandom));
        6, 7, 8: hr(o, tag_of(o), g);
        9: begin o = $urandom_range(0, 3); hr(o, tag_of(o), g); end
        10: hw($urandom_range(0, 1), 8'($urandom));
        default: dw(8'($urandom));
      endcase
    end
    chk("R9", dev_h2d, m_h2d);
    chk("R9", dev_d2h, m_d2h);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule